// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands with a single W-bit adder, spending one clock cycle per multiplier bit. A one-cycle start request, taken only while the unit is idle, captures both operands. The multiplicand goes into a fixed register and the multiplier goes into the low-half register. The high-half accumulator starts at zero.

On every working cycle the unit looks at the lowest bit of the low-half register. If that bit is 1 it adds the multiplicand to the accumulator, and if it is 0 it adds zero. The (W+1)-bit result is then shifted right by one place across the accumulator and the low-half register together. Multiplier bits leave the low half at the bottom while finished product bits enter it at the top.

After W such cycles a done flag is raised for one cycle. The 2W-bit product is then on the product port, with the accumulator as its upper half, and it stays there until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: A start sampled high while busy is low loads the operands. On the following cycle busy is 1, done is 0, the product port's upper W bits are 0 and its lower W bits equal the multiplier.
- R2: On a working cycle where product bit 0 is 1, the next value of product bits [2W-1:W-1] equals the previous upper half plus the captured multiplicand, computed W+1 bits wide with the adder carry as the top bit.
- R3: On a working cycle where product bit 0 is 0, the next value of product bits [2W-1:W-1] equals the previous upper half with a 0 above it. The accumulator is shifted right and its value is not otherwise changed.
- R4: On every working cycle, the next value of product bits [W-2:0] equals the previous product bits [W-1:1].
- R5: Done is high for exactly one cycle. It rises W clock edges after the edge that accepted start. Busy is high from the accepted start through the done cycle.
- R6: While done is high, the product equals the captured multiplicand times the captured multiplier. The product holds its value while idle until the next accepted start.
- R7: A start sampled while busy is high, including the done cycle, is ignored. It affects neither the running product nor the return to idle.
- R8: A synchronous active-low reset leaves busy at 0, done at 0 and the product at 0.
- R9: With W = 4, multiplicand 1101 and multiplier 1011 pass through the products 0x6D, 0x9E, 0x4F and 0x8F (143) on the four working cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiplication, taken only when idle |
| multiplicand | input | W | Multiplicand, sampled with an accepted start |
| multiplier | input | W | Multiplier, sampled with an accepted start |
| busy | output | 1 | High from the accepted start until the end of the done cycle |
| done | output | 1 | One-cycle flag marking a finished product |
| product | output | 2W | Accumulator (upper half) joined with the low-half register |

## Verification
The assertions take for granted that the operand inputs matter only at the edge that accepts start. For that reason the checker keeps its own copy of the operands taken at acceptance and never reads the operand ports during a run. They also assume W is at least 2, so that the low-half shift check has a bit range. They expect reset to be held low for at least one edge before any run. The stimulus changes inputs only on falling edges and holds reset for several edges. It pulses start during working cycles and during the done cycle to exercise the ignore rule. It covers every operand pair at W = 4 plus corner and random pairs at W = 8.

// File: rtl/mult_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes nothing beyond a two-bit state encoding.
package mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mult_state_e;
endpackage

// File: rtl/mult_adder.sv
// Ripple-carry adder of W bits built from a generated chain of full adders.
// Assumes W >= 1; carry-in is fixed at zero.
module mult_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = op_a[i] ^ op_b[i] ^ carry[i];
        assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & (op_a[i] ^ op_b[i]));
    end

    assign cout = carry[W];
endmodule

// File: rtl/mult_ctrl.sv
// Control sequencer: idle / run / done with a step counter.
// Assumes W >= 1; start is honoured only in the idle state.
module mult_ctrl
    import mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int          CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mult_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)         state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Step counter: cleared on load, advanced on each working cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // Decoded controls.
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
    end
endmodule

// File: rtl/mult_datapath.sv
// Datapath: multiplicand register, accumulator and low-half register,
// with a zero/multiplicand select ahead of one W-bit adder. Add and
// right shift happen in the same cycle, so the carry never needs storage.
// Assumes load and step are never high together.
module mult_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] acc,
    output logic [W-1:0] low
);
    logic [W-1:0] mcand_q, acc_q, low_q;
    logic [W-1:0] addend, sum;
    logic         cout;

    // Add/no-add select driven by the low-half LSB.
    always_comb addend = low_q[0] ? mcand_q : '0;

    mult_adder #(.W(W)) u_add (
        .op_a (acc_q),
        .op_b (addend),
        .sum  (sum),
        .cout (cout)
    );

    // Operand capture and combined add-then-shift of carry:acc:low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            low_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand;
            acc_q   <= '0;
            low_q   <= mplier;
        end else if (step) begin
            acc_q   <= {cout, sum[W-1:1]};
            low_q   <= {sum[0], low_q[W-1:1]};
        end
    end

    assign acc = acc_q;
    assign low = low_q;
endmodule

// File: rtl/shift_add_mult.sv
// Top of the sequential unsigned multiplier: W cycles per product.
// Assumes operands are valid at the edge that accepts start.
module shift_add_mult #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic         load, step;
    logic [W-1:0] acc, low;

    mult_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mult_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mcand  (multiplicand),
        .mplier (multiplier),
        .acc    (acc),
        .low    (low)
    );

    assign product = {acc, low};
endmodule

// File: rtl/shift_add_mult_chk.sv
// Property checker for shift_add_mult, attached by bind.
// Assumes W >= 2 and reset low for at least one edge before use.
module shift_add_mult_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   multiplicand,
    input logic [W-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    logic [W-1:0] op_m, op_q;
    logic [31:0]  lat_q;
    logic         accept, working;

    assign accept  = start && !busy;
    assign working = busy && !done;

    // Private copy of the accepted operands and a latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_m  <= '0;
            op_q  <= '0;
            lat_q <= '0;
        end else if (accept) begin
            op_m  <= multiplicand;
            op_q  <= multiplier;
            lat_q <= '0;
        end else if (busy) begin
            lat_q <= lat_q + 1;
        end
    end

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy && !done && product == {{W{1'b0}}, $past(multiplier)});

    a_r2_add: assert property (@(posedge clk) disable iff (!rst_n)
        working && product[0] |=>
        product[2*W-1:W-1] == ({1'b0, $past(product[2*W-1:W])} + {1'b0, op_m}));

    a_r3_no_add: assert property (@(posedge clk) disable iff (!rst_n)
        working && !product[0] |=>
        product[2*W-1:W-1] == {1'b0, $past(product[2*W-1:W])});

    a_r4_low_shift: assert property (@(posedge clk) disable iff (!rst_n)
        working |=> product[W-2:0] == $past(product[W-1:1]));

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && lat_q == 32'(W));

    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == ({{W{1'b0}}, op_m} * {{W{1'b0}}, op_q}));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> product == $past(product));

    a_r7_ignore_run: assert property (@(posedge clk) disable iff (!rst_n)
        working && start |=> busy);

    a_r7_ignore_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r8_reset: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && product == '0);
endmodule

bind shift_add_mult shift_add_mult_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/test_shift_add_mult.sv
`timescale 1ns/1ps
module test_shift_add_mult;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;

    logic        start8 = 1'b0, start4 = 1'b0;
    logic [7:0]  mc8 = '0, mp8 = '0;
    logic [3:0]  mc4 = '0, mp4 = '0;
    logic        busy8, done8, busy4, done4;
    logic [15:0] prod8;
    logic [7:0]  prod4;

    logic [15:0] e8_q[$];
    int          t8_q[$];
    logic [15:0] e4_q[$];
    int          t4_q[$];
    logic        pd8 = 1'b0, pd4 = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shift_add_mult #(.W(8)) i_shift_add_mult (
        .clk (clk), .rst_n (rst_n), .start (start8),
        .multiplicand (mc8), .multiplier (mp8),
        .busy (busy8), .done (done8), .product (prod8)
    );

    shift_add_mult #(.W(4)) i_shift_add_mult_n4 (
        .clk (clk), .rst_n (rst_n), .start (start4),
        .multiplicand (mc4), .multiplier (mp4),
        .busy (busy4), .done (done4), .product (prod4)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver for the wide instance: waits for idle, pulses start, queues expectation.
    task automatic issue8(input logic [7:0] m, input logic [7:0] q);
        @(negedge clk);
        while (busy8) @(negedge clk);
        start8 = 1'b1; mc8 = m; mp8 = q;
        e8_q.push_back(16'(m) * 16'(q));
        t8_q.push_back(cyc);
        @(negedge clk);
        start8 = 1'b0;
    endtask

    // Driver for the narrow instance.
    task automatic issue4(input logic [3:0] m, input logic [3:0] q);
        @(negedge clk);
        while (busy4) @(negedge clk);
        start4 = 1'b1; mc4 = m; mp4 = q;
        e4_q.push_back(16'(8'(m) * 8'(q)));
        t4_q.push_back(cyc);
        @(negedge clk);
        start4 = 1'b0;
    endtask

    // Scoreboard monitor: pops on done, compares product and latency (R5, R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (done8) begin
                if (e8_q.size() == 0) check(1'b0, "R7 unexpected done8", 32'(prod8), 0);
                else begin
                    logic [15:0] e; int t;
                    e = e8_q.pop_front(); t = t8_q.pop_front();
                    check(prod8 == e, "R6 product8", 32'(prod8), 32'(e));
                    check(cyc == t + 9, "R5 latency8", 32'(cyc), 32'(t + 9));
                end
                if (pd8) check(1'b0, "R5 pulse8", 1, 0);
            end
            if (done4) begin
                if (e4_q.size() == 0) check(1'b0, "R7 unexpected done4", 32'(prod4), 0);
                else begin
                    logic [15:0] e; int t;
                    e = e4_q.pop_front(); t = t4_q.pop_front();
                    check(16'(prod4) == e, "R6 product4", 32'(prod4), 32'(e));
                    check(cyc == t + 5, "R5 latency4", 32'(cyc), 32'(t + 5));
                end
                if (pd4) check(1'b0, "R5 pulse4", 1, 0);
            end
        end
        pd8 = done8;
        pd4 = done4;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'(cyc), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(!busy8 && !done8, "R8 flags8", {busy8, done8}, 0);
        check(prod8 == 16'h0, "R8 product8", 32'(prod8), 0);
        check(!busy4 && !done4 && prod4 == 8'h0, "R8 narrow", 32'(prod4), 0);

        // R9 worked case, traced cycle by cycle (R1, R2, R3, R4)
        issue4(4'hD, 4'hB);
        check(busy4 && !done4 && prod4 == 8'h0B, "R1 load", 32'(prod4), 32'h0B);
        @(negedge clk);
        check(prod4 == 8'h6D, "R2 R4 R9 step1", 32'(prod4), 32'h6D);
        @(negedge clk);
        check(prod4 == 8'h9E, "R2 R4 R9 step2 carry", 32'(prod4), 32'h9E);
        @(negedge clk);
        check(prod4 == 8'h4F, "R3 R4 R9 step3", 32'(prod4), 32'h4F);
        @(negedge clk);
        check(prod4 == 8'h8F, "R2 R9 step4", 32'(prod4), 32'h8F);
        check(done4, "R5 done4 on final", 32'(done4), 1);

        // R7: start during working cycles and during done is ignored
        issue8(8'd200, 8'd250);
        start8 = 1'b1; mc8 = 8'd3; mp8 = 8'd3;
        @(negedge clk);
        start8 = 1'b0;
        while (!done8) @(negedge clk);
        start8 = 1'b1; mc8 = 8'd7; mp8 = 8'd7;
        @(negedge clk);
        start8 = 1'b0;
        check(!busy8, "R7 start in done ignored", 32'(busy8), 0);
        repeat (5) @(negedge clk);
        check(!busy8 && prod8 == 16'd50000, "R6 R7 hold", 32'(prod8), 32'd50000);

        // Corner operands at W=8
        issue8(8'hFF, 8'hFF);
        issue8(8'h00, 8'hA5);
        issue8(8'h5A, 8'h00);
        issue8(8'h01, 8'hFF);
        issue8(8'h80, 8'h02);
        issue8(8'hFF, 8'h01);
        for (int k = 0; k < 300; k++) issue8(8'($urandom), 8'($urandom));

        // Exhaustive at W=4
        for (int m = 0; m < 16; m++)
            for (int q = 0; q < 16; q++)
                issue4(4'(m), 4'(q));

        repeat (20) @(negedge clk);
        check(e8_q.size() == 0 && e4_q.size() == 0, "R5 all results seen",
              32'(e8_q.size() + e4_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule